// File: doc/BRIEF.md
# Line-Oriented ASCII Command Interpreter

This block sits behind an external UART receiver and turns typed text lines into register writes for a synthesizer control path. Each byte arrives with a one-cycle valid strobe. A line holds a short mnemonic and an operand. A carriage return or a line feed ends the line. The block checks the operand against the range that the command allows. When the command is accepted it updates one of its held settings: output phase offset, sine amplitude, clock divider value, prescaler enable, square-output enable, character echo, update mode or serial rate divisor.

Every non-empty line gets a four-byte reply, which leaves through a valid/ready byte handshake toward the UART transmitter. The reply is either an acknowledgement or a question mark followed by a code character that names the fault. Received characters can optionally be sent back ahead of the reply. A one-cycle update strobe tells the downstream synthesizer when to apply new settings. The strobe follows every accepted command in automatic mode. In manual mode it follows only an explicit request.

Top module: `cmd_interp`

## Requirements
- R1: A byte of 0x0D or 0x0A ends a line. If the line holds no characters (for example the second byte of a CR LF pair), the terminator produces no reply, no write and no update strobe.
- R2: Every reply is two characters followed by 0x0D 0x0A. Success sends "OK". A failure sends '?' and then a code character. The first reply byte is offered on tx_byte in the cycle after the clock edge that takes the terminator. While tx_ready is low, tx_valid stays high and tx_byte stays unchanged.
- R3: The mnemonic is one or two characters and is matched without regard to case. A single space separates it from the operand. An unknown mnemonic, or one longer than two characters, replies "?0" and writes nothing.
- R4: "P0 n" sets phase_o to the decimal value n when 0 <= n <= 16383. Any other value, or any non-digit character, replies "?4" and leaves phase_o unchanged.
- R5: "V0 n" sets amp_o when n is 0 to 1023 and made of digits only, so a decimal point is refused. Any other operand replies "?7" and leaves amp_o unchanged.
- R6: "D0 n" sets div_o to n when n is 0 to 65535. Any other operand replies "?8" and leaves div_o unchanged.
- R7: "A x" and "PR x" take x = E (enable) or D (disable), in either case, and drive cmos_en_o or presc_en_o. Any other operand replies "?8".
- R8: "Kb h" takes a hexadecimal value from 1 to 255 and sets baud_div_o, where the rate is 1152/h kBaud. Zero, a larger value or a non-hex character replies "?8" and leaves baud_div_o unchanged.
- R9: "E E" and "E D" switch echo on and off. While echo is on, every received byte, terminator included, is sent on tx before the reply to its line. The echo setting that was in force when a byte arrived decides whether that byte is echoed.
- R10: "I a" selects automatic update, "I m" selects manual update, and "I p" requests one update. upd_pulse_o is high for one cycle, the cycle after the terminator edge, in two cases: an accepted command while automatic mode was in force before that line, or an accepted "I p".
- R11: A line of more than 32 characters, terminator excluded, replies "?3" and writes nothing. Characters past the 32nd are discarded.
- R12: After reset: phase_o 0, amp_o 1023, div_o 0, both enables off, echo off, automatic update on, baud_div_o 0x3C, tx_valid low.
- R13: Settings change only in the cycle after the clock edge that takes a terminator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | tx_byte holds a byte to send |
| tx_byte | output | 8 | Byte to transmit (echo or reply) |
| phase_o | output | 14 | Phase offset setting |
| amp_o | output | 10 | Amplitude setting |
| div_o | output | 16 | Square-output divider setting |
| presc_en_o | output | 1 | Divide-by-two prescaler enable |
| cmos_en_o | output | 1 | Square-output enable |
| echo_en_o | output | 1 | Character echo enable |
| auto_upd_o | output | 1 | Automatic update mode |
| baud_div_o | output | 8 | Serial rate divisor |
| upd_pulse_o | output | 1 | Update strobe to the synthesizer |

## Verification
The terminator is taken at one clock edge, and every result of the line is registered at that same edge. The settings and upd_pulse_o are therefore sampled at the falling edge that follows it, and the strobe must be low again one cycle later. The first reply byte (or the echo of the terminator) is checked at that same falling edge while tx_ready is held low. It is checked again several cycles later to show it is held. The full reply stream is collected only after a fixed drain window, because with tx_ready high the reply takes four further cycles, plus one for each pending echo.

// File: rtl/cmdi_pkg.sv
package cmdi_pkg;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_SP = 8'h20;

    typedef enum logic [3:0] {
        OP_NONE, OP_PHASE, OP_AMP, OP_DIV, OP_PRESC,
        OP_CMOS, OP_ECHO, OP_UPD, OP_BAUD
    } op_e;

    typedef enum logic [2:0] {
        RSP_OK, RSP_UNKNOWN, RSP_LONG, RSP_PHASE, RSP_AMP, RSP_ARG
    } rsp_e;

    // update-mode operand encodings
    localparam logic [1:0] UPD_AUTO   = 2'd0;
    localparam logic [1:0] UPD_MANUAL = 2'd1;
    localparam logic [1:0] UPD_PULSE  = 2'd2;

    typedef struct packed {
        logic [1:0] cnt;     // operand characters seen, saturating at 3
        logic [7:0] first;   // first operand character, upper case
        logic       dec_ok;  // all characters decimal digits
        logic       hex_ok;  // all characters hexadecimal digits
    } opnd_t;

    function automatic logic [7:0] upcase(input logic [7:0] c);
        return (c >= 8'h61 && c <= 8'h7A) ? c - 8'h20 : c;
    endfunction

    function automatic logic is_dec(input logic [7:0] c);
        return c >= 8'h30 && c <= 8'h39;
    endfunction

    function automatic logic is_hex(input logic [7:0] cu);
        return is_dec(cu) || (cu >= 8'h41 && cu <= 8'h46);
    endfunction

    function automatic logic [3:0] nib_of(input logic [7:0] cu);
        logic [7:0] t;
        t = is_dec(cu) ? cu - 8'h30 : cu - 8'h37;
        return t[3:0];
    endfunction

    function automatic logic [15:0] rsp_pair(input rsp_e r);
        case (r)
            RSP_OK:      return {8'h4F, 8'h4B};
            RSP_UNKNOWN: return {8'h3F, 8'h30};
            RSP_LONG:    return {8'h3F, 8'h33};
            RSP_PHASE:   return {8'h3F, 8'h34};
            RSP_AMP:     return {8'h3F, 8'h37};
            default:     return {8'h3F, 8'h38};
        endcase
    endfunction

endpackage

// File: rtl/cmdi_scan.sv
module cmdi_scan
    import cmdi_pkg::*;
#(
    parameter int LINE_DEPTH = 32,
    parameter int VAL_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             line_end,
    output logic             line_ovf,
    output logic [7:0]       mn0,
    output logic [7:0]       mn1,
    output logic [1:0]       mn_cnt,
    output logic             mn_bad,
    output opnd_t            opnd,
    output logic [VAL_W-1:0] dec_val,
    output logic             dec_big,
    output logic [VAL_W-1:0] hex_val,
    output logic             hex_big
);
    localparam int LEN_W = $clog2(LINE_DEPTH + 1);

    logic [LEN_W-1:0] len_q;
    logic             ovf_q;
    logic             in_op_q;
    logic [7:0]       up;
    logic [3:0]       nib;
    logic             is_term;
    logic [VAL_W+3:0] dnext;
    logic [VAL_W+3:0] hnext;

    assign up       = upcase(rx_byte);
    assign nib      = nib_of(up);
    assign is_term  = (rx_byte == CH_CR) || (rx_byte == CH_LF);
    assign line_end = rx_valid && is_term && ((len_q != '0) || ovf_q);
    assign line_ovf = ovf_q;
    assign dnext    = {4'b0, dec_val} * (VAL_W+4)'(10) + {VAL_W'(0), nib};
    assign hnext    = {hex_val, nib};

    always_ff @(posedge clk) begin
        if (rst || (rx_valid && is_term)) begin
            len_q   <= '0;
            ovf_q   <= 1'b0;
            in_op_q <= 1'b0;
            mn0     <= '0;
            mn1     <= '0;
            mn_cnt  <= '0;
            mn_bad  <= 1'b0;
            opnd    <= '{cnt: 2'd0, first: 8'd0, dec_ok: 1'b1, hex_ok: 1'b1};
            dec_val <= '0;
            dec_big <= 1'b0;
            hex_val <= '0;
            hex_big <= 1'b0;
        end else if (rx_valid) begin
            if (len_q == LEN_W'(LINE_DEPTH)) begin
                ovf_q <= 1'b1;
            end else begin
                len_q <= len_q + 1'b1;
                if (!in_op_q) begin
                    if (rx_byte == CH_SP) begin
                        if (mn_cnt != 2'd0) in_op_q <= 1'b1;
                    end else if (mn_cnt == 2'd0) begin
                        mn0    <= up;
                        mn_cnt <= 2'd1;
                    end else if (mn_cnt == 2'd1) begin
                        mn1    <= up;
                        mn_cnt <= 2'd2;
                    end else begin
                        mn_bad <= 1'b1;
                    end
                end else if (!(rx_byte == CH_SP && opnd.cnt == 2'd0)) begin
                    if (opnd.cnt == 2'd0) opnd.first <= up;
                    if (opnd.cnt != 2'd3) opnd.cnt <= opnd.cnt + 1'b1;
                    if (is_dec(up)) begin
                        if (!dec_big) begin
                            if (dnext[VAL_W+3:VAL_W] != 4'd0) dec_big <= 1'b1;
                            else dec_val <= dnext[VAL_W-1:0];
                        end
                    end else begin
                        opnd.dec_ok <= 1'b0;
                    end
                    if (is_hex(up)) begin
                        if (!hex_big) begin
                            if (hnext[VAL_W+3:VAL_W] != 4'd0) hex_big <= 1'b1;
                            else hex_val <= hnext[VAL_W-1:0];
                        end
                    end else begin
                        opnd.hex_ok <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cmdi_decode.sv
module cmdi_decode
    import cmdi_pkg::*;
#(
    parameter int PHASE_W = 14,
    parameter int AMP_W   = 10,
    parameter int DIV_W   = 16,
    parameter int BAUD_W  = 8,
    parameter int VAL_W   = 16
) (
    input  logic [7:0]       mn0,
    input  logic [7:0]       mn1,
    input  logic [1:0]       mn_cnt,
    input  logic             mn_bad,
    input  opnd_t            opnd,
    input  logic [VAL_W-1:0] dec_val,
    input  logic             dec_big,
    input  logic [VAL_W-1:0] hex_val,
    input  logic             hex_big,
    output op_e              op,
    output rsp_e             rsp,
    output logic [VAL_W-1:0] val
);
    localparam logic [VAL_W-1:0] PHASE_MAX = VAL_W'((1 << PHASE_W) - 1);
    localparam logic [VAL_W-1:0] AMP_MAX   = VAL_W'((1 << AMP_W) - 1);
    localparam logic [VAL_W-1:0] DIV_MAX   = VAL_W'((1 << DIV_W) - 1);
    localparam logic [VAL_W-1:0] BAUD_MAX  = VAL_W'((1 << BAUD_W) - 1);

    op_e  kind;
    logic num_ok;
    logic one_ch;
    logic ok;

    assign num_ok = (opnd.cnt != 2'd0) && opnd.dec_ok && !dec_big;
    assign one_ch = (opnd.cnt == 2'd1);

    always_comb begin
        kind = OP_NONE;
        if (!mn_bad && mn_cnt == 2'd1) begin
            case (mn0)
                "A":     kind = OP_CMOS;
                "E":     kind = OP_ECHO;
                "I":     kind = OP_UPD;
                default: kind = OP_NONE;
            endcase
        end else if (!mn_bad && mn_cnt == 2'd2) begin
            case ({mn0, mn1})
                "P0":    kind = OP_PHASE;
                "V0":    kind = OP_AMP;
                "D0":    kind = OP_DIV;
                "PR":    kind = OP_PRESC;
                "KB":    kind = OP_BAUD;
                default: kind = OP_NONE;
            endcase
        end
    end

    always_comb begin
        ok  = 1'b0;
        val = dec_val;
        rsp = RSP_ARG;
        case (kind)
            OP_PHASE: begin
                ok  = num_ok && dec_val <= PHASE_MAX;
                rsp = ok ? RSP_OK : RSP_PHASE;
            end
            OP_AMP: begin
                ok  = num_ok && dec_val <= AMP_MAX;
                rsp = ok ? RSP_OK : RSP_AMP;
            end
            OP_DIV: begin
                ok  = num_ok && dec_val <= DIV_MAX;
                rsp = ok ? RSP_OK : RSP_ARG;
            end
            OP_PRESC, OP_CMOS, OP_ECHO: begin
                ok  = one_ch && (opnd.first == "E" || opnd.first == "D");
                val = VAL_W'(opnd.first == "E");
                rsp = ok ? RSP_OK : RSP_ARG;
            end
            OP_UPD: begin
                ok  = one_ch && (opnd.first == "A" || opnd.first == "M" || opnd.first == "P");
                val = (opnd.first == "A") ? VAL_W'(UPD_AUTO) :
                      (opnd.first == "M") ? VAL_W'(UPD_MANUAL) : VAL_W'(UPD_PULSE);
                rsp = ok ? RSP_OK : RSP_ARG;
            end
            OP_BAUD: begin
                ok  = (opnd.cnt != 2'd0) && opnd.hex_ok && !hex_big &&
                      hex_val != '0 && hex_val <= BAUD_MAX;
                val = hex_val;
                rsp = ok ? RSP_OK : RSP_ARG;
            end
            default: begin
                ok  = 1'b0;
                rsp = RSP_UNKNOWN;
            end
        endcase
        op = ok ? kind : OP_NONE;
    end
endmodule

// File: rtl/cmdi_tx.sv
module cmdi_tx
    import cmdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       echo_req,
    input  logic [7:0] echo_byte,
    input  logic       rsp_start,
    input  rsp_e       rsp_code,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    logic        echo_pend;
    logic [7:0]  echo_q;
    logic        busy;
    logic [1:0]  idx;
    logic [15:0] pair;
    logic [7:0]  rsp_byte;
    logic        take;

    always_comb begin
        case (idx)
            2'd0:    rsp_byte = pair[15:8];
            2'd1:    rsp_byte = pair[7:0];
            2'd2:    rsp_byte = CH_CR;
            default: rsp_byte = CH_LF;
        endcase
    end

    assign tx_valid = echo_pend || busy;
    assign tx_byte  = echo_pend ? echo_q : rsp_byte;
    assign take     = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_pend <= 1'b0;
            echo_q    <= '0;
            busy      <= 1'b0;
            idx       <= '0;
            pair      <= '0;
        end else begin
            if (echo_req) begin
                echo_pend <= 1'b1;
                echo_q    <= echo_byte;
            end else if (take && echo_pend) begin
                echo_pend <= 1'b0;
            end
            if (rsp_start) begin
                busy <= 1'b1;
                idx  <= '0;
                pair <= rsp_pair(rsp_code);
            end else if (take && !echo_pend && busy) begin
                if (idx == 2'd3) busy <= 1'b0;
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
    import cmdi_pkg::*;
#(
    parameter int LINE_DEPTH = 32,
    parameter int PHASE_W    = 14,
    parameter int AMP_W      = 10,
    parameter int DIV_W      = 16,
    parameter int BAUD_W     = 8,
    parameter logic [BAUD_W-1:0] BAUD_RESET = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic [PHASE_W-1:0] phase_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              presc_en_o,
    output logic              cmos_en_o,
    output logic              echo_en_o,
    output logic              auto_upd_o,
    output logic [BAUD_W-1:0] baud_div_o,
    output logic              upd_pulse_o
);
    localparam int W1    = (DIV_W > PHASE_W) ? DIV_W : PHASE_W;
    localparam int W2    = (W1 > AMP_W) ? W1 : AMP_W;
    localparam int VAL_W = (W2 > BAUD_W) ? W2 : BAUD_W;

    logic             line_end, line_ovf;
    logic [7:0]       mn0, mn1;
    logic [1:0]       mn_cnt;
    logic             mn_bad;
    opnd_t            opnd;
    logic [VAL_W-1:0] dec_val, hex_val, val;
    logic             dec_big, hex_big;
    op_e              op;
    rsp_e             rsp;
    logic             wr;

    cmdi_scan #(.LINE_DEPTH(LINE_DEPTH), .VAL_W(VAL_W)) u_scan (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_end(line_end), .line_ovf(line_ovf),
        .mn0(mn0), .mn1(mn1), .mn_cnt(mn_cnt), .mn_bad(mn_bad), .opnd(opnd),
        .dec_val(dec_val), .dec_big(dec_big), .hex_val(hex_val), .hex_big(hex_big)
    );

    cmdi_decode #(.PHASE_W(PHASE_W), .AMP_W(AMP_W), .DIV_W(DIV_W),
                  .BAUD_W(BAUD_W), .VAL_W(VAL_W)) u_dec (
        .mn0(mn0), .mn1(mn1), .mn_cnt(mn_cnt), .mn_bad(mn_bad), .opnd(opnd),
        .dec_val(dec_val), .dec_big(dec_big), .hex_val(hex_val), .hex_big(hex_big),
        .op(op), .rsp(rsp), .val(val)
    );

    cmdi_tx u_tx (
        .clk(clk), .rst(rst),
        .echo_req(rx_valid && echo_en_o), .echo_byte(rx_byte),
        .rsp_start(line_end), .rsp_code(line_ovf ? RSP_LONG : rsp),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    assign wr = line_end && !line_ovf && (op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o     <= '0;
            amp_o       <= '1;
            div_o       <= '0;
            presc_en_o  <= 1'b0;
            cmos_en_o   <= 1'b0;
            echo_en_o   <= 1'b0;
            auto_upd_o  <= 1'b1;
            baud_div_o  <= BAUD_RESET;
            upd_pulse_o <= 1'b0;
        end else begin
            upd_pulse_o <= wr && (auto_upd_o ||
                           (op == OP_UPD && val[1:0] == UPD_PULSE));
            if (wr) begin
                case (op)
                    OP_PHASE: phase_o    <= val[PHASE_W-1:0];
                    OP_AMP:   amp_o      <= val[AMP_W-1:0];
                    OP_DIV:   div_o      <= val[DIV_W-1:0];
                    OP_PRESC: presc_en_o <= val[0];
                    OP_CMOS:  cmos_en_o  <= val[0];
                    OP_ECHO:  echo_en_o  <= val[0];
                    OP_BAUD:  baud_div_o <= val[BAUD_W-1:0];
                    OP_UPD: begin
                        if (val[1:0] == UPD_AUTO)   auto_upd_o <= 1'b1;
                        if (val[1:0] == UPD_MANUAL) auto_upd_o <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_interp_chk.sv
module cmd_interp_chk #(
    parameter int PHASE_W = 14,
    parameter int AMP_W   = 10,
    parameter int DIV_W   = 16,
    parameter int BAUD_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               rx_valid,
    input logic               tx_ready,
    input logic               tx_valid,
    input logic [7:0]         tx_byte,
    input logic [PHASE_W-1:0] phase_o,
    input logic [AMP_W-1:0]   amp_o,
    input logic [DIV_W-1:0]   div_o,
    input logic               presc_en_o,
    input logic               cmos_en_o,
    input logic               echo_en_o,
    input logic               auto_upd_o,
    input logic [BAUD_W-1:0]  baud_div_o,
    input logic               upd_pulse_o
);
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        upd_pulse_o |=> !upd_pulse_o);

    p_pulse_after_rx_r10: assert property (@(posedge clk) disable iff (rst)
        upd_pulse_o |-> $past(rx_valid));

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !rx_valid) |=> (tx_valid && $stable(tx_byte)));

    p_baud_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        baud_div_o != '0);

    p_quiet_regs_r13: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable({phase_o, amp_o, div_o, presc_en_o, cmos_en_o,
                               echo_en_o, auto_upd_o, baud_div_o}));
endmodule

bind cmd_interp cmd_interp_chk #(
    .PHASE_W(PHASE_W), .AMP_W(AMP_W), .DIV_W(DIV_W), .BAUD_W(BAUD_W)
) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .phase_o(phase_o), .amp_o(amp_o),
    .div_o(div_o), .presc_en_o(presc_en_o), .cmos_en_o(cmos_en_o),
    .echo_en_o(echo_en_o), .auto_upd_o(auto_upd_o), .baud_div_o(baud_div_o),
    .upd_pulse_o(upd_pulse_o)
);

// File: tb/cmd_interp_bench.sv
`timescale 1ns/1ps
module cmd_interp_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic        tx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [13:0] phase_o;
    logic [9:0]  amp_o;
    logic [15:0] div_o;
    logic        presc_en_o, cmos_en_o, echo_en_o, auto_upd_o, upd_pulse_o;
    logic [7:0]  baud_div_o;

    int checks = 0;
    int errors = 0;
    byte cap [0:127];
    int  ncap = 0;

    always #2.5 clk = ~clk;

    cmd_interp u_cmd_interp (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .phase_o(phase_o), .amp_o(amp_o), .div_o(div_o),
        .presc_en_o(presc_en_o), .cmos_en_o(cmos_en_o), .echo_en_o(echo_en_o),
        .auto_upd_o(auto_upd_o), .baud_div_o(baud_div_o), .upd_pulse_o(upd_pulse_o)
    );

    // record each byte that the next rising edge will hand over
    always @(negedge clk) begin
        #1;
        if (tx_valid && tx_ready && ncap < 128) begin
            cap[ncap] = tx_byte;
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input byte b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // send a line ended by CR; check the strobe one cycle after the terminator edge
    task automatic send(input string s, input bit pulse, input string req);
        ncap = 0;
        for (int i = 0; i < s.len(); i++) put(s[i]);
        put(8'h0D);
        chk(upd_pulse_o == pulse, req, {"update strobe after '", s, "'"},
            upd_pulse_o, pulse);
        @(negedge clk);
        chk(upd_pulse_o == 1'b0, "R10", "strobe lasts one cycle", upd_pulse_o, 0);
    endtask

    task automatic expect_tx(input string e, input string req);
        repeat (14) @(negedge clk);
        chk(ncap == e.len(), req, "reply length", ncap, e.len());
        for (int i = 0; i < e.len() && i < ncap; i++)
            chk(cap[i] == e[i], req, $sformatf("reply byte %0d", i), cap[i], e[i]);
    endtask

    task automatic t_reset;
        chk(phase_o == 0, "R12", "phase reset", phase_o, 0);
        chk(amp_o == 1023, "R12", "amp reset", amp_o, 1023);
        chk(div_o == 0, "R12", "div reset", div_o, 0);
        chk({presc_en_o, cmos_en_o, echo_en_o} == 3'b000, "R12", "enables reset",
            {presc_en_o, cmos_en_o, echo_en_o}, 0);
        chk(auto_upd_o == 1, "R12", "auto mode reset", auto_upd_o, 1);
        chk(baud_div_o == 8'h3C, "R12", "baud reset", baud_div_o, 8'h3C);
        chk(tx_valid == 0, "R12", "tx idle", tx_valid, 0);
    endtask

    task automatic t_phase;
        send("P0 12345", 1, "R4"); expect_tx("OK\r\n", "R4");
        chk(phase_o == 12345, "R4", "phase write", phase_o, 12345);
        send("p0 16384", 0, "R4"); expect_tx("?4\r\n", "R4");
        chk(phase_o == 12345, "R4", "phase kept", phase_o, 12345);
        send("P0 16383", 1, "R4"); expect_tx("OK\r\n", "R4");
        chk(phase_o == 16383, "R4", "phase max", phase_o, 16383);
        send("P0 1x", 0, "R4"); expect_tx("?4\r\n", "R4");
    endtask

    task automatic t_amp;
        send("V0 1023", 1, "R5"); expect_tx("OK\r\n", "R5");
        send("V0 12", 1, "R5"); expect_tx("OK\r\n", "R5");
        chk(amp_o == 12, "R5", "amp write", amp_o, 12);
        send("V0 1024", 0, "R5"); expect_tx("?7\r\n", "R5");
        send("v0 10.5", 0, "R5"); expect_tx("?7\r\n", "R5");
        chk(amp_o == 12, "R5", "amp kept", amp_o, 12);
    endtask

    task automatic t_div;
        send("D0 65535", 1, "R6"); expect_tx("OK\r\n", "R6");
        chk(div_o == 65535, "R6", "div max", div_o, 65535);
        send("D0 65536", 0, "R6"); expect_tx("?8\r\n", "R6");
        chk(div_o == 65535, "R6", "div kept", div_o, 65535);
    endtask

    task automatic t_enables;
        send("A e", 1, "R7"); expect_tx("OK\r\n", "R7");
        send("pr E", 1, "R7"); expect_tx("OK\r\n", "R7");
        chk({cmos_en_o, presc_en_o} == 2'b11, "R7", "enables on",
            {cmos_en_o, presc_en_o}, 3);
        send("A X", 0, "R7"); expect_tx("?8\r\n", "R7");
        send("PR d", 1, "R7"); expect_tx("OK\r\n", "R7");
        chk({cmos_en_o, presc_en_o} == 2'b10, "R7", "prescaler off",
            {cmos_en_o, presc_en_o}, 2);
    endtask

    task automatic t_mnemonic;
        send("XY 5", 0, "R3"); expect_tx("?0\r\n", "R3");
        send("P05", 0, "R3"); expect_tx("?0\r\n", "R3");
        chk(phase_o == 16383, "R3", "no write on unknown", phase_o, 16383);
    endtask

    task automatic t_baud;
        send("Kb 0a", 1, "R8"); expect_tx("OK\r\n", "R8");
        chk(baud_div_o == 8'h0A, "R8", "baud write", baud_div_o, 10);
        send("KB 0", 0, "R8"); expect_tx("?8\r\n", "R8");
        send("kb 1FF", 0, "R8"); expect_tx("?8\r\n", "R8");
        send("Kb zz", 0, "R8"); expect_tx("?8\r\n", "R8");
        chk(baud_div_o == 8'h0A, "R8", "baud kept", baud_div_o, 10);
    endtask

    task automatic t_terminators;
        ncap = 0;
        put(8'h0D);
        put(8'h0A);
        chk(upd_pulse_o == 0, "R1", "no strobe on empty line", upd_pulse_o, 0);
        expect_tx("", "R1");
        send("V0 7", 1, "R1");
        put(8'h0A);
        expect_tx("OK\r\n", "R1");
        chk(amp_o == 7, "R1", "amp after CR LF", amp_o, 7);
    endtask

    task automatic t_long;
        ncap = 0;
        put("P"); put("0"); put(" ");
        for (int i = 0; i < 37; i++) put("1");
        put(8'h0D);
        chk(upd_pulse_o == 0, "R11", "no strobe on long line", upd_pulse_o, 0);
        expect_tx("?3\r\n", "R11");
        chk(phase_o == 16383, "R11", "phase kept", phase_o, 16383);
        send("P0 100", 1, "R11"); expect_tx("OK\r\n", "R11");
    endtask

    task automatic t_echo;
        send("E E", 1, "R9"); expect_tx("OK\r\n", "R9");
        chk(echo_en_o == 1, "R9", "echo on", echo_en_o, 1);
        send("E D", 1, "R9"); expect_tx("E D\rOK\r\n", "R9");
        chk(echo_en_o == 0, "R9", "echo off", echo_en_o, 0);
    endtask

    task automatic t_update;
        send("I m", 1, "R10"); expect_tx("OK\r\n", "R10");
        chk(auto_upd_o == 0, "R10", "manual mode", auto_upd_o, 0);
        send("P0 5", 0, "R10"); expect_tx("OK\r\n", "R10");
        send("I p", 1, "R10"); expect_tx("OK\r\n", "R10");
        send("I a", 0, "R10"); expect_tx("OK\r\n", "R10");
        send("P0 6", 1, "R10"); expect_tx("OK\r\n", "R10");
        chk(phase_o == 6, "R10", "phase after auto", phase_o, 6);
    endtask

    task automatic t_stall;
        tx_ready = 1'b0;
        ncap = 0;
        put("D"); put("0"); put(" "); put("9");
        chk(div_o == 65535, "R13", "no change before terminator", div_o, 65535);
        put(8'h0D);
        chk(div_o == 9, "R13", "div in cycle after terminator", div_o, 9);
        chk(tx_valid == 1 && tx_byte == 8'h4F, "R2", "first reply byte",
            tx_byte, 8'h4F);
        repeat (5) @(negedge clk);
        chk(tx_valid == 1 && tx_byte == 8'h4F, "R2", "reply held", tx_byte, 8'h4F);
        tx_ready = 1'b1;
        expect_tx("OK\r\n", "R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rx_valid = 1'b0;
        rx_byte = 8'h00;
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_phase;
        t_amp;
        t_div;
        t_enables;
        t_mnemonic;
        t_baud;
        t_terminators;
        t_long;
        t_echo;
        t_update;
        t_stall;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule